// File: doc/BRIEF.md
# Indexed Host Register Port for an Audio Codec

This block is the byte-wide host side of an audio codec's control logic. An ISA-style bus master reaches it with a 2-bit address, an active-low chip select, and active-low read and write strobes. These strobes are asynchronous to the block clock. The four direct locations are an index latch, a data window, a status byte and a sample data location. The data window leads to sixteen byte-wide control registers. The index latch chooses which of these registers the window reaches. The control registers are presented to the rest of the codec as one flat vector.

Location 3 is really two registers. A host write there hands a playback byte to the codec and raises a one-clock strobe. A host read there returns the capture byte that the codec supplies, and raises a one-clock acknowledge once the read ends. The status byte shows seven live bits from the codec and one sticky interrupt flag. The interrupt flag is gated onto the interrupt pin by an enable bit in control register 10. Two combinational outputs steer an external byte transceiver: one enables it and the other sets its direction.

After reset, bit 7 of the index location reads 1 for a programmable number of clocks and then reads 0.

Top module: `codec_host_port`

## Requirements
- R1: Reads are combinational from the current address while `hcs_n` is low. Address 0 returns {busy, bit 6 latch, bit 5 latch, 0, index[3:0]}. Address 2 returns {stat_in[7:1], interrupt flag}. Address 3 returns `cap_data`.
- R2: A write to address 0 stores index bits 3:0, the bit 5 latch and the bit 6 latch. Written bits 7 and 4 have no effect; bit 4 always reads 0.
- R3: A read or write at address 1 reaches the control register selected by the current index. Register k appears on `ctrl_regs[8k+7:8k]`, and the other registers keep their contents.
- R4: A write to address 3 places the byte on `play_data` and pulses `play_stb` for exactly one clock. It does not change what a read of address 3 returns.
- R5: A completed read of address 3 pulses `cap_taken` for exactly one clock.
- R6: A one-clock `irq_set` pulse sets the interrupt flag on the next clock. The flag then stays set until the host writes any value to address 2, which clears it.
- R7: `irq` is high only while the interrupt flag is set and bit 1 of control register 10 is 1.
- R8: `bus_en` is high while `hcs_n` is low and either strobe is low. `bus_dir` is high only while `hcs_n` and `hrd_n` are both low.
- R9: Reset sets the index to 0, clears all control registers and the interrupt flag, and sets the busy bit. The busy bit reads 0 from INIT_CYCLES clocks after reset is released.
- R10: A write takes effect exactly once, within four clocks of the rising edge of `hwr_n`. A strobe pulse while `hcs_n` is high changes nothing.
- R11: Status bits 7:1 follow `stat_in` with no storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| hcs_n | input | 1 | Host chip select, active low |
| hrd_n | input | 1 | Host read strobe, active low |
| hwr_n | input | 1 | Host write strobe, active low |
| haddr | input | 2 | Direct location select |
| hdata_in | input | 8 | Host write data |
| hdata_out | output | 8 | Host read data |
| bus_en | output | 1 | Transceiver enable |
| bus_dir | output | 1 | Transceiver direction, 1 = toward host |
| stat_in | input | 7 | Live status bits 7:1 from the codec |
| irq_set | input | 1 | Interrupt event pulse from the codec |
| irq | output | 1 | Gated interrupt output |
| cap_data | input | 8 | Capture byte from the codec |
| cap_taken | output | 1 | One-clock pulse after a capture read |
| play_data | output | 8 | Last playback byte written |
| play_stb | output | 1 | One-clock pulse on a playback write |
| ctrl_regs | output | 128 | Control registers, register k at bits 8k+7:8k |
| mode_chg_en | output | 1 | Bit 6 latch of the index location |
| xfer_req_dis | output | 1 | Bit 5 latch of the index location |

## Verification
A corrupted index would send a write to the wrong control register. That error would be visible on `ctrl_regs` and on the next window read within four clocks of the strobe. An interrupt flag that fails to stick or fails to clear shows at once in status bit 0 and on `irq`. A synchronizer that produces the commit edge twice or never shows up as a strobe count on `play_stb` or `cap_taken` that differs from the number of host accesses.

// File: rtl/codec_host_port.sv
module codec_host_port #(
  parameter int INIT_CYCLES = 256,
  parameter int NREG = 16,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hcs_n,
  input  logic                hrd_n,
  input  logic                hwr_n,
  input  logic [1:0]          haddr,
  input  logic [DW-1:0]       hdata_in,
  output logic [DW-1:0]       hdata_out,
  output logic                bus_en,
  output logic                bus_dir,
  input  logic [DW-1:1]       stat_in,
  input  logic                irq_set,
  output logic                irq,
  input  logic [DW-1:0]       cap_data,
  output logic                cap_taken,
  output logic [DW-1:0]       play_data,
  output logic                play_stb,
  output logic [NREG*DW-1:0]  ctrl_regs,
  output logic                mode_chg_en,
  output logic                xfer_req_dis
);
  localparam int IW = $clog2(NREG);
  localparam int CW = $clog2(INIT_CYCLES + 1);
  localparam int IRQ_EN_REG = 10;
  localparam int IRQ_EN_BIT = 1;

  logic [2:0]    wr_sy, rd_sy;
  logic          wr_rise, rd_rise, commit;
  logic          wr_hold_v, rd_hold_cap;
  logic [1:0]    wr_addr_h;
  logic [DW-1:0] wr_data_h;
  logic [IW-1:0] idx;
  logic          irq_flag;
  logic [CW-1:0] busy_cnt;
  logic          busy;
  logic [DW-1:0] regs [NREG];

  assign wr_rise = wr_sy[1] & ~wr_sy[2];
  assign rd_rise = rd_sy[1] & ~rd_sy[2];
  assign commit  = wr_rise & wr_hold_v;
  assign busy    = (busy_cnt != '0);

  assign bus_en  = ~hcs_n & (~hrd_n | ~hwr_n);
  assign bus_dir = ~hcs_n & ~hrd_n;
  assign irq     = irq_flag & regs[IRQ_EN_REG][IRQ_EN_BIT];

  for (genvar k = 0; k < NREG; k++) begin : g_flat
    assign ctrl_regs[k*DW +: DW] = regs[k];
  end

  always_comb begin
    case (haddr)
      2'd0:    hdata_out = {busy, mode_chg_en, xfer_req_dis, 1'b0, idx};
      2'd1:    hdata_out = regs[idx];
      2'd2:    hdata_out = {stat_in, irq_flag};
      default: hdata_out = cap_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sy <= '1;
      rd_sy <= '1;
    end else begin
      wr_sy <= {wr_sy[1:0], hwr_n};
      rd_sy <= {rd_sy[1:0], hrd_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_hold_v   <= 1'b0;
      wr_addr_h   <= '0;
      wr_data_h   <= '0;
      rd_hold_cap <= 1'b0;
    end else begin
      if (!wr_sy[1]) begin
        wr_hold_v <= ~hcs_n;
        wr_addr_h <= haddr;
        wr_data_h <= hdata_in;
      end else if (wr_rise) begin
        wr_hold_v <= 1'b0;
      end
      if (!rd_sy[1])    rd_hold_cap <= ~hcs_n & (haddr == 2'd3);
      else if (rd_rise) rd_hold_cap <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx          <= '0;
      mode_chg_en  <= 1'b0;
      xfer_req_dis <= 1'b0;
      irq_flag     <= 1'b0;
      busy_cnt     <= CW'(INIT_CYCLES);
      play_data    <= '0;
      play_stb     <= 1'b0;
      cap_taken    <= 1'b0;
      for (int k = 0; k < NREG; k++) regs[k] <= '0;
    end else begin
      play_stb  <= commit && (wr_addr_h == 2'd3);
      cap_taken <= rd_rise && rd_hold_cap;
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (irq_set) irq_flag <= 1'b1;
      else if (commit && wr_addr_h == 2'd2) irq_flag <= 1'b0;
      if (commit) begin
        case (wr_addr_h)
          2'd0: begin
            idx          <= wr_data_h[IW-1:0];
            xfer_req_dis <= wr_data_h[5];
            mode_chg_en  <= wr_data_h[6];
          end
          2'd1:    regs[idx] <= wr_data_h;
          2'd3:    play_data <= wr_data_h;
          default: ;
        endcase
      end
    end
  end

  assert_irq_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq_flag);
  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !(commit && wr_addr_h == 2'd2)) |=> irq_flag);
  assert_index_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && wr_addr_h == 2'd0) |=> $stable(idx));
  assert_busy_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);
  assert_play_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    play_stb |=> !play_stb);
  assert_cap_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_taken |=> !cap_taken);
  assert_single_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
endmodule

// File: tb/test_codec_host_port.sv
module test_codec_host_port;
  localparam int INIT = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hcs_n = 1'b1, hrd_n = 1'b1, hwr_n = 1'b1;
  logic [1:0] haddr = '0;
  logic [7:0] hdata_in = '0, hdata_out, cap_data = '0, play_data;
  logic bus_en, bus_dir, irq, irq_set = 1'b0, cap_taken, play_stb;
  logic [7:1] stat_in = '0;
  logic [127:0] ctrl_regs;
  logic mode_chg_en, xfer_req_dis;
  int checks = 0, fails = 0, play_cnt = 0, cap_cnt = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  codec_host_port #(.INIT_CYCLES(INIT)) i_codec_host_port (
    .clk(clk), .rst_n(rst_n), .hcs_n(hcs_n), .hrd_n(hrd_n), .hwr_n(hwr_n),
    .haddr(haddr), .hdata_in(hdata_in), .hdata_out(hdata_out),
    .bus_en(bus_en), .bus_dir(bus_dir), .stat_in(stat_in), .irq_set(irq_set),
    .irq(irq), .cap_data(cap_data), .cap_taken(cap_taken),
    .play_data(play_data), .play_stb(play_stb), .ctrl_regs(ctrl_regs),
    .mode_chg_en(mode_chg_en), .xfer_req_dis(xfer_req_dis));

  always @(posedge clk) begin
    if (play_stb) play_cnt++;
    if (cap_taken) cap_cnt++;
  end

  // {is_read, addr, write data, expected read}
  localparam logic [18:0] VEC [10] = '{
    {1'b0, 2'd0, 8'h05, 8'h00}, {1'b0, 2'd1, 8'hA5, 8'h00},
    {1'b1, 2'd1, 8'h00, 8'hA5}, {1'b0, 2'd0, 8'hF3, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h63}, {1'b0, 2'd1, 8'h3C, 8'h00},
    {1'b1, 2'd1, 8'h00, 8'h3C}, {1'b0, 2'd0, 8'h05, 8'h00},
    {1'b1, 2'd1, 8'h00, 8'hA5}, {1'b1, 2'd0, 8'h00, 8'h05}};

  task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    haddr = a; hdata_in = d; hcs_n = ~sel;
    @(negedge clk); hwr_n = 1'b0;
    repeat (3) @(negedge clk);
    hwr_n = 1'b1;
    repeat (5) @(negedge clk);
    hcs_n = 1'b1;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    haddr = a; hcs_n = 1'b0;
    @(negedge clk); hrd_n = 1'b0;
    repeat (2) @(negedge clk);
    d = hdata_out;
    hrd_n = 1'b1;
    repeat (5) @(negedge clk);
    hcs_n = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int pc, cc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    host_rd(2'd0, rv);
    chk(rv == 8'h80, "R9 busy after reset", rv, 8'h80);
    chk(ctrl_regs == '0 && irq == 1'b0, "R9 regs cleared", ctrl_regs, 0);
    repeat (INIT + 4) @(negedge clk);
    host_rd(2'd0, rv);
    chk(rv == 8'h00, "R9 busy released", rv, 8'h00);

    for (int i = 0; i < 10; i++) begin
      if (VEC[i][18]) begin
        host_rd(VEC[i][17:16], rv);
        chk(rv == VEC[i][7:0], VEC[i][17:16] == 2'd0 ? "R2 index read" : "R3 window read", rv, VEC[i][7:0]);
      end else begin
        host_wr(VEC[i][17:16], VEC[i][15:8]);
      end
    end
    chk(ctrl_regs[47:40] == 8'hA5 && ctrl_regs[31:24] == 8'h3C, "R3 flat vector", ctrl_regs, 0);
    chk(ctrl_regs[127:48] == '0 && ctrl_regs[39:32] == '0 && ctrl_regs[23:0] == '0, "R3 others untouched", ctrl_regs, 0);

    host_wr(2'd1, 8'hFF, 1'b0);
    host_rd(2'd1, rv);
    chk(rv == 8'hA5, "R10 write without select ignored", rv, 8'hA5);

    cap_data = 8'hC3;
    pc = play_cnt;
    host_wr(2'd3, 8'h5A);
    chk(play_cnt == pc + 1 && play_data == 8'h5A, "R4 playback write", play_data, 8'h5A);
    chk(play_cnt == pc + 1, "R10 one commit per strobe", play_cnt - pc, 1);
    cc = cap_cnt;
    host_rd(2'd3, rv);
    chk(rv == 8'hC3, "R1 capture read", rv, 8'hC3);
    chk(cap_cnt == cc + 1, "R5 capture ack", cap_cnt - cc, 1);

    stat_in = 7'h55;
    host_rd(2'd2, rv);
    chk(rv == 8'hAA, "R11 live status", rv, 8'hAA);
    stat_in = 7'h2A;
    host_rd(2'd2, rv);
    chk(rv == 8'h54, "R11 status follows input", rv, 8'h54);

    @(negedge clk); irq_set = 1'b1;
    @(negedge clk); irq_set = 1'b0;
    repeat (10) @(negedge clk);
    host_rd(2'd2, rv);
    chk(rv[0] == 1'b1, "R6 flag sticky", rv, 8'h55);
    chk(irq == 1'b0, "R7 irq masked", irq, 0);
    host_wr(2'd0, 8'h0A);
    host_wr(2'd1, 8'h02);
    chk(irq == 1'b1, "R7 irq enabled", irq, 1);
    host_wr(2'd2, 8'h00);
    host_rd(2'd2, rv);
    chk(rv[0] == 1'b0 && irq == 1'b0, "R6 flag cleared by status write", rv, 8'h54);

    @(negedge clk);
    chk(bus_en == 1'b0 && bus_dir == 1'b0, "R8 idle", {bus_en, bus_dir}, 0);
    hcs_n = 1'b0; hwr_n = 1'b0; #1;
    chk(bus_en == 1'b1 && bus_dir == 1'b0, "R8 write drive", {bus_en, bus_dir}, 2);
    hwr_n = 1'b1; hrd_n = 1'b0; #1;
    chk(bus_en == 1'b1 && bus_dir == 1'b1, "R8 read drive", {bus_en, bus_dir}, 3);
    hcs_n = 1'b1; #1;
    chk(bus_en == 1'b0, "R8 deselected", bus_en, 0);
    hrd_n = 1'b1;
    repeat (5) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule